// File: doc/BRIEF.md
# Serial Command Decoder for an On-Screen Display

This block sits behind a three-wire serial input (active-low select, clock, data) and turns the byte stream into actions for a character overlay. Bytes are collected most significant bit first on rising serial clock edges while the select is low. A byte whose top bit is 1 is an identifier: it names a command and remains the active command for every data byte that follows, until another identifier arrives. Data bytes then either move the display-memory write pointer, update one of nine configuration slots, start a whole-memory erase or, once the character-write identifier has been seen, land in display memory as character entries.

The display memory is a 12 by 24 array of 8-bit entries, and the block drives its write port directly. Each entry holds an attribute flag in bit 7 and a character code below it. The linear address of row r, column c is r*24+c. Character writes advance the pointer across columns and then rows. The erase sweeps all 288 cells with the blank code 7F hex, one cell per clock cycle. The serial pins are sampled by the system clock through two-stage synchronizers, so the serial clock must run well below the system clock.

Top module: `osd_cmd_decoder`

## Requirements
- R1: A byte is assembled from eight rising serial clock edges while `ser_cs_n` is low, first bit into bit 7. A byte that is only partly received when `ser_cs_n` rises is discarded, and the next byte starts afresh.
- R2: A byte with bit 7 = 1 (outside character-write lock) is taken as the identifier and stays in force, so several data bytes in a row are all applied to the same command.
- R3: Identifier 1000rrrr selects set-address with row rrrr. Its data byte carries the column in bits 4:0. The pointer moves only if row < 12 and column < 24. Otherwise the pair is ignored and the pointer keeps its value.
- R4: Identifier 90 hex locks the decoder in character write. Every following byte, including bytes with bit 7 = 1, is written unchanged to address row*24+col, one `mem_we` pulse per byte. Locked bytes never change any configuration slot.
- R5: After each character write the pointer moves to the next column. After column 23 it moves to column 0 of the next row, and after row 11 column 23 it moves to row 0 column 0.
- R6: A rising edge on `ser_cs_n` releases the lock and makes set-address with row 0 the active command. A data byte sent next, with no identifier, sets the column on row 0.
- R7: Identifiers 1010, 1011, 1100, 1101 and 1110 in bits 7:4 select slots 0 to 4. Identifiers 1111 with bits 3:2 = 00, 01, 10 or 11 select slots 5 to 8. A data byte stores {identifier bits 3:0, data bits 6:0} as an 11-bit value into the selected slot, which appears at `cfg_flat[k*11 +: 11]`.
- R8: A data byte received under an identifier 1100x1xx (bit 2 set) starts an erase. For 288 consecutive cycles `erase_busy` is high and `mem_we` writes 7F hex to addresses 0, 1, ... 287 in that order.
- R9: Character bytes that arrive while the erase runs are dropped: no write is made and the pointer does not advance.
- R10: After `rst_n` is deasserted all slots read zero, `erase_busy` and `mem_we` are low, the pointer is row 0 column 0, and no command is active: data bytes sent before any identifier or select release have no effect.
- R11: `mem_addr` is below 288 whenever `mem_we` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_cs_n | input | 1 | Serial select, active low |
| ser_clk | input | 1 | Serial clock, data taken on rising edge |
| ser_din | input | 1 | Serial data, most significant bit first |
| mem_we | output | 1 | Display memory write strobe |
| mem_addr | output | 9 | Display memory linear address |
| mem_wdata | output | 8 | Display memory write data |
| erase_busy | output | 1 | High while the erase sweep runs |
| cfg_flat | output | 99 | Nine 11-bit configuration slots, slot k at bits k*11+10 to k*11 |

## Verification
Character writes are tried with a pointer placed in mid-screen, at the last cell of a row and at the very last cell, so a linear address that does not wrap rows or the screen shows up. Identifier and data sequences are sent with repeated data bytes, with out-of-range rows and columns, with bytes that have bit 7 set inside the lock, and with a truncated byte before a select release. These separate identifier persistence, range filtering, lock handling and byte framing. The erase is started with character bytes sent during the sweep, and the pointer is checked afterwards, which separates a true drop from a delayed write.

// File: rtl/osd_cmd_pkg.sv
package osd_cmd_pkg;

  localparam int BYTE_W = 8;
  localparam int CFG_N  = 9;
  localparam int CFG_W  = 11;
  localparam int SLOT_W = 4;
  localparam logic [7:0] CHAR_ID   = 8'h90;
  localparam logic [7:0] ADDR_ID   = 8'h80;
  localparam logic [7:0] BLANK_VAL = 8'h7F;

  typedef enum logic [1:0] {
    K_NONE,
    K_ADDR,
    K_CHAR,
    K_REG
  } cmd_kind_e;

  function automatic cmd_kind_e decode_kind(input logic [7:0] id);
    if (!id[7])                 return K_NONE;
    if (id[6:4] == 3'b000)      return K_ADDR;
    if (id == CHAR_ID)          return K_CHAR;
    if (id[6:4] == 3'b001)      return K_NONE;
    return K_REG;
  endfunction

  function automatic logic [SLOT_W-1:0] cfg_slot(input logic [7:0] id);
    if (id[6:4] == 3'b111) return 4'd5 + {2'b00, id[3:2]};
    return {1'b0, id[6:4]} - 4'd2;
  endfunction

  function automatic int lin_addr(input int row, input int col, input int cols);
    return row * cols + col;
  endfunction

endpackage

// File: rtl/osd_ser_rx.sv
module osd_ser_rx #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n_i,
  input  logic              sclk_i,
  input  logic              sdin_i,
  output logic              byte_vld_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic              cs_rise_o
);
  localparam int CNT_W = $clog2(BYTE_W);

  logic [1:0] cs_sy, ck_sy, dt_sy;
  logic       cs_prev, ck_prev;
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] shf_q;
  logic              ck_rise;

  assign ck_rise   = ck_sy[1] & ~ck_prev;
  assign cs_rise_o = cs_sy[1] & ~cs_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_sy      <= 2'b11;
      ck_sy      <= 2'b00;
      dt_sy      <= 2'b00;
      cs_prev    <= 1'b1;
      ck_prev    <= 1'b0;
      cnt_q      <= '0;
      shf_q      <= '0;
      byte_vld_o <= 1'b0;
      byte_o     <= '0;
    end else begin
      cs_sy      <= {cs_sy[0], cs_n_i};
      ck_sy      <= {ck_sy[0], sclk_i};
      dt_sy      <= {dt_sy[0], sdin_i};
      cs_prev    <= cs_sy[1];
      ck_prev    <= ck_sy[1];
      byte_vld_o <= 1'b0;
      if (cs_sy[1]) begin
        cnt_q <= '0;
      end else if (ck_rise) begin
        shf_q <= {shf_q[BYTE_W-2:0], dt_sy[1]};
        if (int'(cnt_q) == BYTE_W - 1) begin
          cnt_q      <= '0;
          byte_vld_o <= 1'b1;
          byte_o     <= {shf_q[BYTE_W-2:0], dt_sy[1]};
        end else begin
          cnt_q <= cnt_q + CNT_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/osd_cmd_fsm.sv
module osd_cmd_fsm
  import osd_cmd_pkg::*;
#(
  parameter int ROWS   = 12,
  parameter int COLS   = 24,
  parameter int ADDR_W = 9
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             byte_vld_i,
  input  logic [7:0]                       byte_i,
  input  logic                             cs_rise_i,
  input  logic                             erase_busy_i,
  output logic                             wr_en_o,
  output logic [ADDR_W-1:0]                wr_addr_o,
  output logic [7:0]                       wr_data_o,
  output logic                             erase_start_o,
  output logic                             locked_o,
  output logic [CFG_N-1:0][CFG_W-1:0]      cfg_o
);
  localparam int ROW_W = $clog2(ROWS);
  localparam int COL_W = $clog2(COLS);

  logic [7:0]       id_q;
  logic             locked_q;
  logic [ROW_W-1:0] row_q;
  logic [COL_W-1:0] col_q;

  cmd_kind_e          kind;
  logic               is_id, is_data, char_go, addr_go, addr_ok, reg_go;
  logic [SLOT_W-1:0]  slot;

  assign kind    = decode_kind(id_q);
  assign is_id   = byte_vld_i && !locked_q && byte_i[7];
  assign is_data = byte_vld_i && !is_id;
  assign char_go = is_data && locked_q && !erase_busy_i;
  assign addr_ok = (int'(id_q[3:0]) < ROWS) && (int'(byte_i[4:0]) < COLS);
  assign addr_go = is_data && !locked_q && (kind == K_ADDR) && addr_ok;
  assign reg_go  = is_data && !locked_q && (kind == K_REG);
  assign slot    = cfg_slot(id_q);
  assign erase_start_o = reg_go && (id_q[6:4] == 3'b100) && id_q[2] && !erase_busy_i;
  assign locked_o = locked_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      id_q      <= '0;
      locked_q  <= 1'b0;
      row_q     <= '0;
      col_q     <= '0;
      wr_en_o   <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
    end else begin
      wr_en_o <= 1'b0;
      if (cs_rise_i) begin
        id_q     <= ADDR_ID;
        locked_q <= 1'b0;
      end else if (is_id) begin
        id_q     <= byte_i;
        locked_q <= (byte_i == CHAR_ID);
      end else if (addr_go) begin
        row_q <= ROW_W'(id_q[3:0]);
        col_q <= COL_W'(byte_i[4:0]);
      end else if (char_go) begin
        wr_en_o   <= 1'b1;
        wr_addr_o <= ADDR_W'(lin_addr(int'(row_q), int'(col_q), COLS));
        wr_data_o <= byte_i;
        if (int'(col_q) == COLS - 1) begin
          col_q <= '0;
          row_q <= (int'(row_q) == ROWS - 1) ? '0 : row_q + ROW_W'(1);
        end else begin
          col_q <= col_q + COL_W'(1);
        end
      end
    end
  end

  for (genvar g = 0; g < CFG_N; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        cfg_o[g] <= '0;
      else if (reg_go && (slot == SLOT_W'(g)))
        cfg_o[g] <= {id_q[3:0], byte_i[6:0]};
    end
  end
endmodule

// File: rtl/osd_erase_seq.sv
module osd_erase_seq #(
  parameter int CELLS  = 288,
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  output logic              busy_o,
  output logic [ADDR_W-1:0] addr_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_o <= 1'b0;
      addr_o <= '0;
    end else if (start_i && !busy_o) begin
      busy_o <= 1'b1;
      addr_o <= '0;
    end else if (busy_o) begin
      if (int'(addr_o) == CELLS - 1) begin
        busy_o <= 1'b0;
        addr_o <= '0;
      end else begin
        addr_o <= addr_o + ADDR_W'(1);
      end
    end
  end
endmodule

// File: rtl/osd_cmd_decoder.sv
module osd_cmd_decoder
  import osd_cmd_pkg::*;
#(
  parameter int ROWS = 12,
  parameter int COLS = 24,
  localparam int CELLS  = ROWS * COLS,
  localparam int ADDR_W = $clog2(CELLS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ser_cs_n,
  input  logic                   ser_clk,
  input  logic                   ser_din,
  output logic                   mem_we,
  output logic [ADDR_W-1:0]      mem_addr,
  output logic [7:0]             mem_wdata,
  output logic                   erase_busy,
  output logic [CFG_N*CFG_W-1:0] cfg_flat
);
  logic                        rx_vld;
  logic [7:0]                  rx_byte;
  logic                        cs_rise;
  logic                        chr_we;
  logic [ADDR_W-1:0]           chr_addr;
  logic [7:0]                  chr_data;
  logic                        ers_start;
  logic                        locked;
  logic [ADDR_W-1:0]           ers_addr;
  logic [CFG_N-1:0][CFG_W-1:0] cfg_arr;

  osd_ser_rx #(.BYTE_W(BYTE_W)) u_rx (
    .clk(clk), .rst_n(rst_n),
    .cs_n_i(ser_cs_n), .sclk_i(ser_clk), .sdin_i(ser_din),
    .byte_vld_o(rx_vld), .byte_o(rx_byte), .cs_rise_o(cs_rise)
  );

  osd_cmd_fsm #(.ROWS(ROWS), .COLS(COLS), .ADDR_W(ADDR_W)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .byte_vld_i(rx_vld), .byte_i(rx_byte), .cs_rise_i(cs_rise),
    .erase_busy_i(erase_busy),
    .wr_en_o(chr_we), .wr_addr_o(chr_addr), .wr_data_o(chr_data),
    .erase_start_o(ers_start), .locked_o(locked), .cfg_o(cfg_arr)
  );

  osd_erase_seq #(.CELLS(CELLS), .ADDR_W(ADDR_W)) u_ers (
    .clk(clk), .rst_n(rst_n),
    .start_i(ers_start), .busy_o(erase_busy), .addr_o(ers_addr)
  );

  assign mem_we    = erase_busy | chr_we;
  assign mem_addr  = erase_busy ? ers_addr : chr_addr;
  assign mem_wdata = erase_busy ? BLANK_VAL : chr_data;
  assign cfg_flat  = cfg_arr;
endmodule

// File: rtl/osd_cmd_decoder_chk.sv
module osd_cmd_decoder_chk #(
  parameter int CELLS  = 288,
  parameter int ADDR_W = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [7:0]        mem_wdata,
  input logic              erase_busy,
  input logic              rx_vld,
  input logic              cs_rise,
  input logic              chr_we,
  input logic              locked
);
  int busy_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_run <= 0;
    else        busy_run <= erase_busy ? busy_run + 1 : 0;
  end

  always_ff @(posedge clk) begin
    if (rst_n) a_r8_busy_len: assert (busy_run <= CELLS);
  end

  a_r8_erase_fill: assert property (@(posedge clk) disable iff (!rst_n)
    erase_busy |-> (mem_we && mem_wdata == 8'h7F));

  a_r8_erase_begin: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(erase_busy) |-> (mem_addr == '0));

  a_r8_erase_step: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_busy && $past(erase_busy)) |-> (mem_addr == $past(mem_addr) + ADDR_W'(1)));

  a_r11_addr_range: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (int'(mem_addr) < CELLS));

  a_r9_no_char_in_erase: assert property (@(posedge clk) disable iff (!rst_n)
    erase_busy |-> !chr_we);

  a_r4_char_after_byte: assert property (@(posedge clk) disable iff (!rst_n)
    chr_we |-> $past(rx_vld));

  a_r6_unlock: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise |=> !locked);
endmodule

bind osd_cmd_decoder osd_cmd_decoder_chk #(.CELLS(CELLS), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_we(mem_we), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata), .erase_busy(erase_busy), .rx_vld(rx_vld),
  .cs_rise(cs_rise), .chr_we(chr_we), .locked(locked)
);

// File: tb/test_osd_cmd_decoder.sv
`timescale 1ns/1ps
module test_osd_cmd_decoder;
  localparam int CELLS = 288;
  localparam int SW    = 11;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ser_cs_n = 1'b1;
  logic        ser_clk = 1'b0;
  logic        ser_din = 1'b0;
  logic        mem_we;
  logic [8:0]  mem_addr;
  logic [7:0]  mem_wdata;
  logic        erase_busy;
  logic [98:0] cfg_flat;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [7:0] tb_mem [CELLS];
  int wr_count = 0;
  int busy_cycles = 0;
  int ers_next = 0;
  bit ers_order_bad = 0;

  always #2.5 clk = ~clk;

  osd_cmd_decoder i_osd_cmd_decoder (
    .clk(clk), .rst_n(rst_n), .ser_cs_n(ser_cs_n), .ser_clk(ser_clk),
    .ser_din(ser_din), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .erase_busy(erase_busy), .cfg_flat(cfg_flat)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_we) begin
        tb_mem[int'(mem_addr)] = mem_wdata;
        wr_count++;
      end
      if (erase_busy) begin
        busy_cycles++;
        if (int'(mem_addr) != ers_next) ers_order_bad = 1;
        ers_next++;
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int slot_val(input int k);
    return int'(cfg_flat[k*SW +: SW]);
  endfunction

  function automatic int pack_slot(input int nib, input int dat);
    return (nib << 7) | (dat & 8'h7F);
  endfunction

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk); ser_din = b;
    wait_clk(4); ser_clk = 1'b1;
    wait_clk(4); ser_clk = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    wait_clk(4);
  endtask

  task automatic cs_low;
    @(negedge clk); ser_cs_n = 1'b0; wait_clk(4);
  endtask

  task automatic cs_high;
    @(negedge clk); ser_cs_n = 1'b1; wait_clk(6);
  endtask

  task automatic t_reset;
    int w0;
    check("R10 slots zero", int'(cfg_flat == '0), 1);
    check("R10 busy low", int'(erase_busy), 0);
    check("R10 no write", wr_count, 0);
    cs_low; send_byte(8'h05); send_byte(8'h13);
    check("R10 data before identifier inert", wr_count, 0);
    check("R10 slots unchanged", int'(cfg_flat == '0), 1);
    cs_high;
    w0 = wr_count;
    cs_low; send_byte(8'h90); send_byte(8'h41); cs_high;
    check("R10 pointer at 0,0", int'(tb_mem[0]), 8'h41);
    check("R10 single write", wr_count - w0, 1);
  endtask

  task automatic t_setaddr_char;
    int w0 = wr_count;
    cs_low;
    send_byte(8'h83); send_byte(8'h05);
    send_byte(8'h90); send_byte(8'h41); send_byte(8'hC2); send_byte(8'hA5);
    cs_high;
    check("R3 R4 write at 3*24+5", int'(tb_mem[77]), 8'h41);
    check("R4 bit7 byte is data", int'(tb_mem[78]), 8'hC2);
    check("R4 third locked byte", int'(tb_mem[79]), 8'hA5);
    check("R4 write count", wr_count - w0, 3);
    check("R4 locked bytes leave slots", int'(cfg_flat == '0), 1);
  endtask

  task automatic t_wrap;
    cs_low;
    send_byte(8'h8B); send_byte(8'h16);
    send_byte(8'h90); send_byte(8'hB1); send_byte(8'hB2); send_byte(8'hB3);
    cs_high;
    check("R5 col 22 row 11", int'(tb_mem[286]), 8'hB1);
    check("R5 last cell", int'(tb_mem[287]), 8'hB2);
    check("R5 screen wrap to 0", int'(tb_mem[0]), 8'hB3);
    cs_low;
    send_byte(8'h82); send_byte(8'h17);
    send_byte(8'h90); send_byte(8'hC5); send_byte(8'hC6);
    cs_high;
    check("R5 row 2 col 23", int'(tb_mem[71]), 8'hC5);
    check("R5 row wrap to row 3", int'(tb_mem[72]), 8'hC6);
  endtask

  task automatic t_bad_addr;
    int w0 = wr_count;
    cs_low;
    send_byte(8'h84); send_byte(8'h00);
    send_byte(8'h8C); send_byte(8'h01);
    send_byte(8'h81); send_byte(8'h18);
    send_byte(8'h90); send_byte(8'h55);
    cs_high;
    check("R3 out of range ignored", int'(tb_mem[96]), 8'h55);
    check("R3 one write only", wr_count - w0, 1);
  endtask

  task automatic t_release;
    cs_low; send_byte(8'h90); send_byte(8'h11); cs_high;
    cs_low; send_byte(8'h07); send_byte(8'h90); send_byte(8'h33); cs_high;
    check("R6 release gives set-address row 0", int'(tb_mem[7]), 8'h33);
    cs_low;
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    cs_high;
    cs_low; send_byte(8'h90); send_byte(8'h44); cs_high;
    check("R1 partial byte discarded", int'(tb_mem[8]), 8'h44);
  endtask

  task automatic t_regs;
    cs_low;
    send_byte(8'hA5); send_byte(8'h3C);
    check("R7 slot0 first data", slot_val(0), pack_slot(5, 8'h3C));
    send_byte(8'h12);
    check("R2 identifier persists", slot_val(0), pack_slot(5, 8'h12));
    send_byte(8'hF6); send_byte(8'h7F);
    send_byte(8'hEA); send_byte(8'h09);
    send_byte(8'hD1); send_byte(8'h2B);
    cs_high;
    check("R7 extended slot6", slot_val(6), pack_slot(6, 8'h7F));
    check("R7 slot4", slot_val(4), pack_slot(10, 8'h09));
    check("R7 slot3", slot_val(3), pack_slot(1, 8'h2B));
    check("R7 slot1 untouched", slot_val(1), 0);
    check("R7 slot5 untouched", slot_val(5), 0);
  endtask

  task automatic t_erase;
    int w0;
    bit all7f;
    cs_low;
    send_byte(8'h82); send_byte(8'h03);
    w0 = wr_count; busy_cycles = 0; ers_next = 0; ers_order_bad = 0;
    send_byte(8'hC4); send_byte(8'h01);
    send_byte(8'h90);
    check("R8 busy during sweep", int'(erase_busy), 1);
    send_byte(8'h22);
    while (erase_busy) @(negedge clk);
    wait_clk(4);
    check("R8 sweep length", busy_cycles, CELLS);
    check("R9 dropped char, write count", wr_count - w0, CELLS);
    check("R8 ascending order", int'(ers_order_bad), 0);
    all7f = 1;
    for (int i = 0; i < CELLS; i++) if (tb_mem[i] != 8'h7F) all7f = 0;
    check("R8 all blank", int'(all7f), 1);
    check("R7 erase slot2", slot_val(2), pack_slot(4, 8'h01));
    send_byte(8'h66);
    cs_high;
    check("R9 pointer not advanced", int'(tb_mem[51]), 8'h66);
    check("R9 next cell untouched", int'(tb_mem[52]), 8'h7F);
  endtask

  initial begin
    for (int i = 0; i < CELLS; i++) tb_mem[i] = 8'h00;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);
    t_reset;
    t_setaddr_char;
    t_wrap;
    t_bad_addr;
    t_release;
    t_regs;
    t_erase;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule